// File: doc/BRIEF.md
# Parallel LCD Command and Pixel Write Driver

This block drives a parallel LCD panel over a strobe bus with write-only cycles. The panel side has an active-low chip select, a register select, an active-low write strobe, an active-low read strobe, a 16-bit data bus, an active-low panel reset and a power enable. The user side has an 8-bit command code, a word count and a 16-bit data word. A nonzero command code starts a transaction. The block writes the command byte with register select low. It then writes the counted data words with register select high. After each data word it gives a one-cycle `word_sent` pulse, and the user answers that pulse by presenting the next word.

Once system reset is released, the block holds the panel in reset for a programmable number of clocks and only then accepts commands. Typical use is to set the column range with command 0x2A and four bytes (0, 0, 0, 239 for a 240-wide panel), then the row range with command 0x2B and bytes 0, 0, 1, 0x3F for 320 rows. Command 0x2C then streams up to 240×320 pixels.

Top module: `lcd_bus_driver`

## Requirements
- R1: During reset `lcd_on` and `lcd_rst_n` are 0. `lcd_on` is 1 from the first rising edge after reset release. `lcd_rst_n` rises at the RST_HOLD-th rising edge after release and then stays high. `lcd_rd_n` is always 1.
- R2: A command code of 0x00 starts nothing. Any command presented while `lcd_rst_n` is low is ignored: `cmd_busy` stays 0 and `lcd_wr_n` stays 1.
- R3: A nonzero `cmd_code` is accepted at the first rising edge at which the block is idle and out of panel reset. From that edge `cmd_busy` is 1 and `lcd_cs_n` is 0, and the first bus cycle carries `lcd_rs`=0 with `lcd_dq` = {8'h00, cmd_code}.
- R4: Every bus cycle holds `lcd_wr_n` low for exactly WR_LOW clocks and then high for HOLD clocks. `lcd_dq` does not change while the strobe is low or at its rising edge.
- R5: After the command byte, exactly `word_count` data cycles follow back to back, each with `lcd_rs`=1. Each one carries the `data_word` that was present at the edge that ended the previous cycle. The first word is therefore presented together with the command.
- R6: `word_sent` is a one-cycle pulse in the clock right after `lcd_wr_n` rises on a data word, and only then. There is exactly one pulse per data word and none for the command byte.
- R7: `last_word` is 1 for exactly the WR_LOW+HOLD clocks of the final data word's bus cycle and 0 at all other times. It stays 0 when `word_count` is 0.
- R8: `cmd_busy` stays high for (word_count+1)×(WR_LOW+HOLD) clocks. It falls when the last cycle's hold ends, and `lcd_cs_n` returns high at the same edge.
- R9: A command code that changes while `cmd_busy` is 1 has no effect on the transfer in progress.
- R10: When idle the bus rests at `lcd_cs_n`=1, `lcd_wr_n`=1, `lcd_rs`=1 and `lcd_dq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_code | input | CMD_W | Command to send; 0 means idle |
| word_count | input | CNT_W | Number of data words after the command |
| data_word | input | BUS_W | Current data word to write |
| word_sent | output | 1 | One-cycle pulse after each data word is written |
| last_word | output | 1 | High during the final data word's cycle |
| cmd_busy | output | 1 | High from acceptance until the final word completes |
| lcd_on | output | 1 | Panel power enable |
| lcd_rst_n | output | 1 | Panel reset, active low |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, held high |
| lcd_dq | output | BUS_W | Parallel data bus |

## Verification
The bench sweeps the word count from zero to the configured maximum. A zero count exposes a design that streams a phantom data word or keeps busy high past the command cycle. The maximum count exposes a counter that wraps or ends one word early. A bus monitor rebuilds every strobe cycle and checks its low length, its data stability and its contents. A block that launched the next word one clock late would stretch the busy window, and a block that loaded data at the wrong edge would repeat a word or skip one. The bench also changes the command code in the middle of a burst, which would show up as a second register-select-low cycle. It presents a command throughout power-up, which a block that ignored the panel reset gate would accept early.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int CMD_W = 8;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2
  } seq_state_t;
endpackage

// File: rtl/lcd_powerup.sv
module lcd_powerup #(
  parameter int RST_HOLD = 1000
) (
  input  logic clk,
  input  logic rst,
  output logic panel_rst_n,
  output logic panel_on
);
  localparam int CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      panel_rst_n <= 1'b0;
      panel_on    <= 1'b0;
    end else begin
      panel_on <= 1'b1;
      if (!panel_rst_n) begin
        if (cnt == LAST) panel_rst_n <= 1'b1;
        else             cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  rst_stays_released_chk: assert property (@(posedge clk) disable iff (rst)
    panel_rst_n |=> panel_rst_n);
endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen #(
  parameter int WR_LOW = 2,
  parameter int HOLD   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic wr_n,
  output logic rise_evt,
  output logic cyc_end
);
  localparam int PERIOD = WR_LOW + HOLD;
  localparam int PH_W   = $clog2(PERIOD + 1);
  localparam logic [PH_W-1:0] LOW_LAST = PH_W'(WR_LOW - 1);
  localparam logic [PH_W-1:0] END_PH   = PH_W'(PERIOD - 1);

  logic            active;
  logic [PH_W-1:0] ph;

  assign rise_evt = active && (ph == LOW_LAST);
  assign cyc_end  = active && (ph == END_PH);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      ph     <= '0;
      wr_n   <= 1'b1;
    end else if (start) begin
      active <= 1'b1;
      ph     <= '0;
      wr_n   <= 1'b0;
    end else if (active) begin
      if (cyc_end) begin
        active <= 1'b0;
      end else begin
        ph <= ph + 1'b1;
        if (rise_evt) wr_n <= 1'b1;
      end
    end
  end

  // R4
  strobe_min_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((WR_LOW > 1) && $fell(wr_n)) |=> !wr_n);
endmodule

// File: rtl/lcd_word_counter.sv
module lcd_word_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] remaining
);
  always_ff @(posedge clk) begin
    if (rst)       remaining <= '0;
    else if (load) remaining <= load_val;
    else if (dec)  remaining <= remaining - 1'b1;
  end

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    dec |-> (remaining != '0));
endmodule

// File: rtl/lcd_bus_driver.sv
module lcd_bus_driver
  import lcd_drv_pkg::*;
#(
  parameter int MAX_WORDS = 76800,
  parameter int WR_LOW    = 2,
  parameter int HOLD      = 1,
  parameter int RST_HOLD  = 1000,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic [CNT_W-1:0] word_count,
  input  logic [BUS_W-1:0] data_word,
  output logic             word_sent,
  output logic             last_word,
  output logic             cmd_busy,
  output logic             lcd_on,
  output logic             lcd_rst_n,
  output logic             lcd_cs_n,
  output logic             lcd_rs,
  output logic             lcd_wr_n,
  output logic             lcd_rd_n,
  output logic [BUS_W-1:0] lcd_dq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  seq_state_t       state;
  logic [CNT_W-1:0] remaining;
  logic             ready, accept, start;
  logic             rise_evt, cyc_end;
  logic             cmd_fin, data_fin, next_word, finish, last_next;

  lcd_powerup #(.RST_HOLD(RST_HOLD)) u_pwr (
    .clk(clk), .rst(rst), .panel_rst_n(lcd_rst_n), .panel_on(lcd_on)
  );

  assign ready     = lcd_rst_n;
  assign accept    = (state == ST_IDLE) && ready && (cmd_code != '0);
  assign cmd_fin   = cyc_end && (state == ST_CMD);
  assign data_fin  = cyc_end && (state == ST_DATA);
  assign next_word = (cmd_fin && (remaining != '0)) || (data_fin && (remaining != ONE));
  assign finish    = (cmd_fin && (remaining == '0)) || (data_fin && (remaining == ONE));
  assign last_next = cmd_fin ? (remaining == ONE) : (remaining == TWO);
  assign start     = accept || next_word;

  lcd_strobe_gen #(.WR_LOW(WR_LOW), .HOLD(HOLD)) u_strobe (
    .clk(clk), .rst(rst), .start(start),
    .wr_n(lcd_wr_n), .rise_evt(rise_evt), .cyc_end(cyc_end)
  );

  lcd_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .load_val(word_count),
    .dec(data_fin), .remaining(remaining)
  );

  assign lcd_rd_n = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      lcd_cs_n  <= 1'b1;
      lcd_rs    <= 1'b1;
      lcd_dq    <= '0;
      cmd_busy  <= 1'b0;
      last_word <= 1'b0;
      word_sent <= 1'b0;
    end else begin
      word_sent <= rise_evt && (state == ST_DATA);
      if (accept) begin
        state    <= ST_CMD;
        lcd_cs_n <= 1'b0;
        lcd_rs   <= 1'b0;
        lcd_dq   <= {{(BUS_W-CMD_W){1'b0}}, cmd_code};
        cmd_busy <= 1'b1;
      end else if (next_word) begin
        state     <= ST_DATA;
        lcd_rs    <= 1'b1;
        lcd_dq    <= data_word;
        last_word <= last_next;
      end else if (finish) begin
        state     <= ST_IDLE;
        lcd_cs_n  <= 1'b1;
        lcd_rs    <= 1'b1;
        lcd_dq    <= '0;
        cmd_busy  <= 1'b0;
        last_word <= 1'b0;
      end
    end
  end

  // R4
  dq_stable_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n && !$past(lcd_wr_n)) |-> $stable(lcd_dq));
  // R4
  dq_held_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lcd_wr_n) |-> $stable(lcd_dq));
  // R3
  strobe_needs_select_chk: assert property (@(posedge clk) disable iff (rst)
    !lcd_wr_n |-> !lcd_cs_n);
  // R1
  read_idle_chk: assert property (@(posedge clk) disable iff (rst)
    lcd_rd_n);
  // R2
  no_busy_in_panel_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !lcd_rst_n |-> !cmd_busy);
  // R6
  sent_single_chk: assert property (@(posedge clk) disable iff (rst)
    word_sent |=> !word_sent);
  // R6
  sent_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    word_sent |-> ($rose(lcd_wr_n) && lcd_rs));
  // R7
  last_in_data_chk: assert property (@(posedge clk) disable iff (rst)
    last_word |-> (cmd_busy && lcd_rs));
  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    lcd_cs_n |-> (lcd_wr_n && lcd_rs && (lcd_dq == '0)));
endmodule

// File: tb/lcd_bus_driver_bench.sv
`timescale 1ns/1ps
module lcd_bus_driver_bench;
  localparam int MAX_WORDS = 15;
  localparam int WR_LOW    = 2;
  localparam int HOLD      = 1;
  localparam int RST_HOLD  = 5;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int PERIOD    = WR_LOW + HOLD;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       cmd_code = 8'h00;
  logic [CNT_W-1:0] word_count = '0;
  logic [15:0]      data_word = '0;
  logic word_sent, last_word, cmd_busy, lcd_on, lcd_rst_n;
  logic lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n;
  logic [15:0] lcd_dq;

  always #2.5 clk = ~clk;

  lcd_bus_driver #(.MAX_WORDS(MAX_WORDS), .WR_LOW(WR_LOW), .HOLD(HOLD),
                   .RST_HOLD(RST_HOLD)) u_lcd_bus_driver (
    .clk(clk), .rst(rst), .cmd_code(cmd_code), .word_count(word_count),
    .data_word(data_word), .word_sent(word_sent), .last_word(last_word),
    .cmd_busy(cmd_busy), .lcd_on(lcd_on), .lcd_rst_n(lcd_rst_n),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n),
    .lcd_rd_n(lcd_rd_n), .lcd_dq(lcd_dq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bus monitor state
  int ncap, busy_cyc, sent_cnt, sent_bad, last_cyc, last_first, low_err, stab_err, rd_err;
  int lowlen;
  logic prev_wr = 1'b1;
  logic rose;
  logic [15:0] lowdq;
  logic        cap_rs [32];
  logic [15:0] cap_dq [32];

  always @(negedge clk) begin
    if (!rst) begin
      rose = 1'b0;
      if (lcd_rd_n !== 1'b1) rd_err++;
      if (cmd_busy) busy_cyc++;
      if (last_word) begin
        if (last_cyc == 0) last_first = ncap;
        last_cyc++;
      end
      if (!lcd_wr_n) begin
        if (prev_wr) begin lowlen = 1; lowdq = lcd_dq; end
        else begin lowlen++; if (lcd_dq !== lowdq) stab_err++; end
      end else if (!prev_wr) begin
        rose = 1'b1;
        if (lowlen != WR_LOW) low_err++;
        if (lcd_dq !== lowdq) stab_err++;
        if (ncap < 32) begin cap_rs[ncap] = lcd_rs; cap_dq[ncap] = lcd_dq; end
        ncap++;
      end
      if (word_sent) begin
        sent_cnt++;
        if (!rose || !lcd_rs) sent_bad++;
      end
      prev_wr = lcd_wr_n;
    end
  end

  function automatic logic [15:0] word_of(int mode, int base, int i);
    case (mode)
      1: return (i == 3) ? 16'd239 : 16'd0;
      2: return (i == 2) ? 16'd1 : ((i == 3) ? 16'h3F : 16'd0);
      default: return 16'((base * 16'h0901 + i * 16'h1357) ^ 16'hA5C3);
    endcase
  endfunction

  task automatic clear_mon();
    ncap = 0; busy_cyc = 0; sent_cnt = 0; sent_bad = 0; last_cyc = 0;
    last_first = -1; low_err = 0; stab_err = 0;
  endtask

  task automatic run_txn(logic [7:0] cmd, int n, int mode, int base, bit intr);
    int idx = 0, wait_cyc = 0, bad = 0, cmd_cycles = 0;
    @(negedge clk); #1;
    clear_mon();
    word_count = CNT_W'(n);
    data_word  = word_of(mode, base, 0);
    cmd_code   = cmd;
    while (!cmd_busy && wait_cyc < 20) begin @(negedge clk); wait_cyc++; end
    // R3: accepted at the very next edge
    check(cmd_busy && wait_cyc == 1, "R3", "accept latency", wait_cyc, 1);
    cmd_code = 8'h00;
    wait_cyc = 0;
    while (cmd_busy && wait_cyc < 400) begin
      @(negedge clk); wait_cyc++;
      if (word_sent) begin
        idx++;
        data_word = word_of(mode, base, idx);
        if (intr && idx == 1) cmd_code = 8'h55;
        if (intr && idx == 3) cmd_code = 8'h00;
      end
    end
    @(negedge clk); #1;
    check(ncap == n + 1, "R5", "bus cycle count", ncap, n + 1);
    check(cap_rs[0] === 1'b0 && cap_dq[0] === {8'h00, cmd}, "R3", "command byte",
          int'(cap_dq[0]), int'(cmd));
    for (int i = 0; i < n && i + 1 < 32; i++)
      if (cap_rs[i+1] !== 1'b1 || cap_dq[i+1] !== word_of(mode, base, i)) bad++;
    check(bad == 0, "R5", "data word mismatches", bad, 0);
    for (int i = 0; i < ncap && i < 32; i++) if (cap_rs[i] === 1'b0) cmd_cycles++;
    check(cmd_cycles == 1, "R9", "command cycles in burst", cmd_cycles, 1);
    check(low_err == 0, "R4", "strobe low length errors", low_err, 0);
    check(stab_err == 0, "R4", "data stability errors", stab_err, 0);
    check(busy_cyc == (n + 1) * PERIOD, "R8", "busy cycles", busy_cyc, (n + 1) * PERIOD);
    check(sent_cnt == n && sent_bad == 0, "R6", "sent pulses", sent_cnt, n);
    check(last_cyc == ((n > 0) ? PERIOD : 0), "R7", "last cycles", last_cyc,
          (n > 0) ? PERIOD : 0);
    if (n > 0) check(last_first == n, "R7", "last start position", last_first, n);
    check(lcd_cs_n && lcd_wr_n && lcd_rs && lcd_dq == 16'h0 && !cmd_busy, "R10",
          "idle bus after burst", int'(lcd_dq), 0);
  endtask

  initial begin
    int edges = 0;
    bit busy_early = 0, strobe_early = 0;
    rst = 1'b1;
    cmd_code = 8'h11;
    repeat (3) @(negedge clk);
    check(!lcd_on && !lcd_rst_n, "R1", "reset outputs", int'(lcd_on), 0);
    check(lcd_rd_n && !cmd_busy, "R1", "read strobe and busy in reset", int'(cmd_busy), 0);
    check(lcd_cs_n && lcd_wr_n && lcd_rs && lcd_dq == 16'h0, "R10", "idle bus in reset",
          int'(lcd_dq), 0);
    rst = 1'b0;
    while (edges < 50) begin
      @(negedge clk); edges++;
      if (edges == 1) check(lcd_on, "R1", "power enable after release", int'(lcd_on), 1);
      if (cmd_busy) busy_early = 1;
      if (!lcd_wr_n) strobe_early = 1;
      if (lcd_rst_n) break;
    end
    cmd_code = 8'h00;
    check(edges == RST_HOLD, "R1", "panel reset release edge", edges, RST_HOLD);
    check(!busy_early && !strobe_early, "R2", "command ignored in panel reset",
          int'(busy_early), 0);
    word_count = CNT_W'(3);
    data_word = 16'h1234;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cmd_busy || !lcd_cs_n || !lcd_wr_n) busy_early = 1;
    end
    check(!busy_early, "R2", "zero command stays idle", int'(busy_early), 0);

    for (int n = 0; n <= MAX_WORDS; n++)
      run_txn(8'((n * 17 + 3) & 8'hFF), n, 0, n, 1'b0);
    run_txn(8'h2A, 4, 1, 0, 1'b0);
    run_txn(8'h2B, 4, 2, 0, 1'b0);
    run_txn(8'h2C, MAX_WORDS, 0, 99, 1'b1);
    run_txn(8'hFF, 1, 0, 7, 1'b0);
    check(rd_err == 0, "R1", "read strobe low seen", rd_err, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule